// File: doc/BRIEF.md
# Grouped Power-Rail Sequencer

This block brings up the voltage rails of a processor module in five ordered groups. It waits for an external module-enable level. It then turns on the first group of regulator enables. It moves to each later group only when every power-good input that belongs to the group before it has been seen as good. Some rails have no power-good feedback. Those rails are switched with their group but never gate progress. When the last group is good, the module power-good output rises, and the active-low system reset is released after a fixed hold count.

There are three ways the sequence ends early:
- The module enable drops.
- A power-good input that was already reached falls.
- A group fails to report good within a timeout, which also raises a fault flag.

In each case the block first drops module power-good and reset. It then removes the rail groups in reverse order, one group per step interval. The mapping of rails and power-good inputs to groups is held in parameters. One build option moves the two 2.5 V DDR rails and their power-good inputs from the third group to the fourth.

Every input is a slow asynchronous level, so no data path and no handshake exist.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is held, and afterwards for as long as `mod_en` stays low, every bit of `rail_en` is 0 and `mod_pgood`, `sys_rst_n` and `fault` are 0.
- R2: `bias_run`, `mreset_n` and `usb_en` are 1 at all times, including during reset and in the fault state.
- R3: When `mod_en` is high, only group 1 is enabled first: `rail_en[2:0]` (core, 2.3 V, switched 3.3 V).
- R4: Group 1 is rails 0 to 2 with power-good 0 to 2. Group 2 is rails 3 to 9 with power-good 3 to 6; rails 5, 6 and 9 have no feedback. Group 3 is rails 10 to 15 with power-good 7 to 12. Group 4 is rails 16 to 20 with power-good 13 only. Group 5 is rail 21 with power-good 14. Group g+1 turns on only after all power-good inputs of group g are good.
- R5: Each power-good input passes a two-flop synchronizer and must then stay high for `STABLE_CYCLES` clocks before it counts. The next group appears exactly `STABLE_CYCLES`+3 clocks after the input rises. A pulse shorter than that has no effect.
- R6: With `DDR25_LATE`=1, rails 14 and 15 and power-good inputs 11 and 12 belong to group 4 instead of group 3.
- R7: `mod_pgood` rises once group 5 is good. `sys_rst_n` rises exactly `RST_HOLD_CYCLES` clocks later, and falls in the same cycle as `mod_pgood`.
- R8: If the current group is not good within `TIMEOUT_CYCLES` clocks of being enabled, `fault` rises. The groups are then removed in reverse order, one per `STEP_CYCLES`. `fault` stays high with all rails off until `mod_en` goes low.
- R9: When `mod_en` falls, `mod_pgood` and `sys_rst_n` drop first. Groups 5 down to 1 are then removed, one per `STEP_CYCLES`, so all rails are off 5×`STEP_CYCLES` clocks after `mod_pgood` fell.
- R10: If a power-good input of an already-passed group falls, the same ordered shutdown runs without `fault`. The sequence restarts from group 1 if `mod_en` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_en | input | 1 | Module enable, asynchronous level |
| pg_in | input | 15 | Power-good inputs, asynchronous levels |
| rail_en | output | 22 | Regulator enables, index per R4 |
| mod_pgood | output | 1 | Module power-good |
| sys_rst_n | output | 1 | Active-low system reset |
| fault | output | 1 | Sequencing timeout flag |
| bias_run | output | 1 | Regulator bias run, constant 1 |
| mreset_n | output | 1 | Manual reset line, constant 1 |
| usb_en | output | 1 | Auxiliary USB supply enable, constant 1 |

## Verification
The assertions assume several things about the inputs and parameters:
- `rst_n` is low before the first clock edge.
- `mod_en` and every power-good input are levels that may change at any time and are sampled only through the synchronizers.
- All count parameters are at least 1.
- There are no more than seven groups.

The stimulus follows these rules by changing inputs only on the falling clock edge. It drives power-good only for rails whose group is already enabled, except during deliberate short pulses and deliberate drops. It holds each level long enough for the next transition to be seen before the following change is made.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  localparam int unsigned RAIL_COUNT  = 22;
  localparam int unsigned PG_COUNT    = 15;
  localparam int unsigned GROUP_COUNT = 5;
  localparam int unsigned GRP_W       = 3;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RAMP,
    SQ_ON,
    SQ_DOWN,
    SQ_FAULT
  } seq_state_e;

  // group index per rail, GRP_W bits each, rail 0 in the low field
  function automatic logic [RAIL_COUNT*GRP_W-1:0] rail_map(bit late);
    logic [RAIL_COUNT*GRP_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(RAIL_COUNT); i++) begin
      int unsigned g;
      if (i < 3)       g = 1;
      else if (i < 10) g = 2;
      else if (i < 14) g = 3;
      else if (i < 16) g = late ? 4 : 3;
      else if (i < 21) g = 4;
      else             g = 5;
      m[i*GRP_W +: GRP_W] = GRP_W'(g);
    end
    return m;
  endfunction

  // group index per power-good input
  function automatic logic [PG_COUNT*GRP_W-1:0] pg_map(bit late);
    logic [PG_COUNT*GRP_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(PG_COUNT); i++) begin
      int unsigned g;
      if (i < 3)       g = 1;
      else if (i < 7)  g = 2;
      else if (i < 11) g = 3;
      else if (i < 13) g = late ? 4 : 3;
      else if (i < 14) g = 4;
      else             g = 5;
      m[i*GRP_W +: GRP_W] = GRP_W'(g);
    end
    return m;
  endfunction

endpackage

// File: rtl/pg_conditioner.sv
module pg_conditioner #(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic good
);

  localparam int unsigned CW = $clog2(STABLE_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_in};
      if (!sync_q[1]) begin
        cnt_q  <= '0;
        good_q <= 1'b0;
      end else if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
        good_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign good = good_q;

  AST_GOOD_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    good_q |-> $past(raw_in, 3)); // R5

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int unsigned NUM_RAILS      = RAIL_COUNT,
  parameter int unsigned NUM_PGS        = PG_COUNT,
  parameter int unsigned NUM_GROUPS     = GROUP_COUNT,
  parameter logic [NUM_RAILS*GRP_W-1:0] RAIL_MAP = rail_map(1'b0),
  parameter logic [NUM_PGS*GRP_W-1:0]   PG_MAP   = pg_map(1'b0),
  parameter int unsigned TIMEOUT_CYCLES = 50000,
  parameter int unsigned STEP_CYCLES    = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic [NUM_PGS-1:0]   pg_good,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 mod_pgood,
  output logic                 fault
);

  localparam int unsigned GW    = GRP_W;
  localparam int unsigned SLOTS = 1 << GW;
  localparam int unsigned TW    = $clog2(TIMEOUT_CYCLES + 1);
  localparam int unsigned SW    = $clog2(STEP_CYCLES + 1);

  seq_state_e    st_q;
  logic [GW-1:0] lvl_q;
  logic [TW-1:0] tmr_q;
  logic [SW-1:0] stp_q;
  logic [1:0]    en_sync_q;
  logic          en_s;

  logic [SLOTS-1:0] grp_ok;
  logic             below_ok;
  logic             cur_ok;
  logic             all_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_sync_q <= '0;
    else        en_sync_q <= {en_sync_q[0], mod_en};
  end
  assign en_s = en_sync_q[1];

  // per-group good: all member inputs good (an empty group is good)
  assign grp_ok[0] = 1'b1;
  for (genvar g = 1; g < SLOTS; g++) begin : g_grp
    if (g <= NUM_GROUPS) begin : g_real
      logic [NUM_PGS-1:0] member;
      for (genvar i = 0; i < NUM_PGS; i++) begin : g_mem
        assign member[i] = (PG_MAP[i*GW +: GW] == GW'(g));
      end
      assign grp_ok[g] = &(pg_good | ~member);
    end else begin : g_pad
      assign grp_ok[g] = 1'b1;
    end
  end

  always_comb begin
    below_ok = 1'b1;
    for (int g = 1; g <= int'(NUM_GROUPS); g++) begin
      if (GW'(g) < lvl_q && !grp_ok[g]) below_ok = 1'b0;
    end
  end

  assign cur_ok = grp_ok[lvl_q];
  assign all_ok = &grp_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      lvl_q <= '0;
      tmr_q <= '0;
      stp_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (en_s) begin
            st_q  <= SQ_RAMP;
            lvl_q <= GW'(1);
            tmr_q <= '0;
          end
        end
        SQ_RAMP: begin
          if (!en_s || !below_ok) begin
            st_q  <= SQ_DOWN;
            stp_q <= '0;
          end else if (cur_ok) begin
            tmr_q <= '0;
            if (lvl_q == GW'(NUM_GROUPS)) st_q <= SQ_ON;
            else                          lvl_q <= lvl_q + GW'(1);
          end else if (tmr_q == TW'(TIMEOUT_CYCLES - 1)) begin
            st_q  <= SQ_FAULT;
            stp_q <= '0;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        SQ_ON: begin
          if (!en_s || !all_ok) begin
            st_q  <= SQ_DOWN;
            stp_q <= '0;
          end
        end
        SQ_DOWN, SQ_FAULT: begin
          if (lvl_q == '0) begin
            if (st_q == SQ_DOWN || !en_s) st_q <= SQ_IDLE;
          end else if (stp_q == SW'(STEP_CYCLES - 1)) begin
            stp_q <= '0;
            lvl_q <= lvl_q - GW'(1);
          end else begin
            stp_q <= stp_q + SW'(1);
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    assign rail_en[r] = (lvl_q >= RAIL_MAP[r*GW +: GW]);
  end

  assign mod_pgood = (st_q == SQ_ON);
  assign fault     = (st_q == SQ_FAULT);

  AST_ONE_GROUP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |->
      (lvl_q == $past(lvl_q) + GW'(1) || lvl_q + GW'(1) == $past(lvl_q))); // R4
  AST_ADVANCE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == $past(lvl_q) + GW'(1) && $past(lvl_q) != '0) |-> $past(cur_ok)); // R4
  AST_PGOOD_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_pgood) |-> $past(&pg_good)); // R7
  AST_FAULT_ON_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(!cur_ok && en_s)); // R8
  AST_NO_RISE_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q > $past(lvl_q)) |-> $past(st_q == SQ_IDLE || st_q == SQ_RAMP)); // R9

endmodule

// File: rtl/rst_release.sv
module rst_release #(
  parameter int unsigned HOLD_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgood,
  output logic sys_rst_n
);

  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (!pgood)                    cnt_q <= '0;
    else if (cnt_q != HW'(HOLD_CYCLES)) cnt_q <= cnt_q + HW'(1);
  end

  assign sys_rst_n = pgood && (cnt_q == HW'(HOLD_CYCLES));

  AST_RELEASE_AFTER_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(pgood)); // R7

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rail_seq_pkg::*;
#(
  parameter int unsigned NUM_RAILS       = RAIL_COUNT,
  parameter int unsigned NUM_PGS         = PG_COUNT,
  parameter int unsigned NUM_GROUPS      = GROUP_COUNT,
  parameter bit          DDR25_LATE      = 1'b0,
  parameter logic [NUM_RAILS*GRP_W-1:0] RAIL_GROUP_MAP = rail_map(DDR25_LATE),
  parameter logic [NUM_PGS*GRP_W-1:0]   PG_GROUP_MAP   = pg_map(DDR25_LATE),
  parameter int unsigned STABLE_CYCLES   = 16,
  parameter int unsigned TIMEOUT_CYCLES  = 50000,
  parameter int unsigned STEP_CYCLES     = 1000,
  parameter int unsigned RST_HOLD_CYCLES = 2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic [NUM_PGS-1:0]   pg_in,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic                 mod_pgood,
  output logic                 sys_rst_n,
  output logic                 fault,
  output logic                 bias_run,
  output logic                 mreset_n,
  output logic                 usb_en
);

  logic [NUM_PGS-1:0] pg_good;

  for (genvar i = 0; i < NUM_PGS; i++) begin : g_pg
    pg_conditioner #(.STABLE_CYCLES(STABLE_CYCLES)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (pg_in[i]),
      .good   (pg_good[i])
    );
  end

  seq_ctrl #(
    .NUM_RAILS      (NUM_RAILS),
    .NUM_PGS        (NUM_PGS),
    .NUM_GROUPS     (NUM_GROUPS),
    .RAIL_MAP       (RAIL_GROUP_MAP),
    .PG_MAP         (PG_GROUP_MAP),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .STEP_CYCLES    (STEP_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .pg_good   (pg_good),
    .rail_en   (rail_en),
    .mod_pgood (mod_pgood),
    .fault     (fault)
  );

  rst_release #(.HOLD_CYCLES(RST_HOLD_CYCLES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .pgood     (mod_pgood),
    .sys_rst_n (sys_rst_n)
  );

  assign bias_run = 1'b1;
  assign mreset_n = 1'b1;
  assign usb_en   = 1'b1;

  AST_FAULT_KEEPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !sys_rst_n); // R8

endmodule

// File: tb/rail_sequencer_test.sv
`timescale 1ns/1ps
module rail_sequencer_test;

  localparam int STB  = 4;
  localparam int TMO  = 200;
  localparam int STP  = 3;
  localparam int HOLD = 8;

  localparam logic [21:0] L1 = 22'h000007;
  localparam logic [21:0] L2 = 22'h0003FF;
  localparam logic [21:0] L3 = 22'h00FFFF;
  localparam logic [21:0] L4 = 22'h1FFFFF;
  localparam logic [21:0] L5 = 22'h3FFFFF;
  localparam logic [14:0] P1 = 15'h0007;
  localparam logic [14:0] P2 = 15'h0078;
  localparam logic [14:0] P3 = 15'h1F80;
  localparam logic [14:0] P4 = 15'h2000;
  localparam logic [14:0] P5 = 15'h4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0;
  logic [14:0] pg_in = '0;
  logic [21:0] rail_en, rail_en_l;
  logic mod_pgood, sys_rst_n, fault, bias_run, mreset_n, usb_en;
  logic mod_pgood_l, sys_rst_n_l, fault_l, bias_run_l, mreset_n_l, usb_en_l;

  int n_cmp = 0;
  int n_bad = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rail_sequencer #(.STABLE_CYCLES(STB), .TIMEOUT_CYCLES(TMO),
                   .STEP_CYCLES(STP), .RST_HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .pg_in(pg_in),
    .rail_en(rail_en), .mod_pgood(mod_pgood), .sys_rst_n(sys_rst_n),
    .fault(fault), .bias_run(bias_run), .mreset_n(mreset_n), .usb_en(usb_en));

  rail_sequencer #(.DDR25_LATE(1'b1), .STABLE_CYCLES(STB), .TIMEOUT_CYCLES(TMO),
                   .STEP_CYCLES(STP), .RST_HOLD_CYCLES(HOLD)) uut_late (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .pg_in(pg_in),
    .rail_en(rail_en_l), .mod_pgood(mod_pgood_l), .sys_rst_n(sys_rst_n_l),
    .fault(fault_l), .bias_run(bias_run_l), .mreset_n(mreset_n_l), .usb_en(usb_en_l));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver side: queue the next expected snapshot {fault, sys_rst_n, mod_pgood, rail_en}
  task automatic expect_obs(input logic f, input logic r, input logic p,
                            input logic [21:0] rails, input string tag);
    exp_q.push_back({f, r, p, rails});
    tag_q.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rails(input logic [21:0] tgt, input string tag, output int cyc);
    cyc = 0;
    while (rail_en !== tgt && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (rail_en !== tgt) check(tag, 32'(rail_en), 32'(tgt));
  endtask

  task automatic wait_bit(ref logic sig, input logic val, input string tag, output int cyc);
    cyc = 0;
    while (sig !== val && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (sig !== val) check(tag, 32'(sig), 32'(val));
  endtask

  task automatic fixed_outs(input string tag);
    check(tag, {29'd0, bias_run, mreset_n, usb_en}, 32'h7);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: each change of the observed outputs pops one expected snapshot
  initial begin : monitor
    logic [24:0] last;
    logic [24:0] obs;
    logic [24:0] e;
    string t;
    last = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      obs = {fault, sys_rst_n, mod_pgood, rail_en};
      if (obs !== last) begin
        if (exp_q.size() == 0) begin
          check("unexpected output change", 32'(obs), 32'(last));
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, 32'(obs), 32'(e));
        end
        last = obs;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin : driver
    int c;
    // R1 / R2: reset state
    step(3);
    check("R1 outputs in reset", {7'd0, fault, sys_rst_n, mod_pgood, rail_en}, 32'd0);
    fixed_outs("R2 fixed outputs in reset");
    rst_n = 1'b1;
    step(20);
    check("R1 idle while enable low", {7'd0, fault, sys_rst_n, mod_pgood, rail_en}, 32'd0);

    // scenario 1: full bring-up
    expect_obs(0, 0, 0, L1, "R3 group 1 first");
    expect_obs(0, 0, 0, L2, "R4 group 2");
    expect_obs(0, 0, 0, L3, "R4 group 3");
    expect_obs(0, 0, 0, L4, "R4 group 4");
    expect_obs(0, 0, 0, L5, "R4 group 5");
    expect_obs(0, 0, 1, L5, "R7 module power-good");
    expect_obs(0, 1, 1, L5, "R7 reset release");
    mod_en = 1'b1;
    wait_rails(L1, "R3 wait group 1", c);
    pg_in = 15'h0006;
    step(10);
    pg_in[0] = 1'b1;
    step(2);
    pg_in[0] = 1'b0;
    step(20);
    check("R5 short pulse ignored", 32'(rail_en), 32'(L1));
    pg_in[0] = 1'b1;
    wait_rails(L2, "R5 wait group 2", c);
    check("R5 filter latency", c, STB + 3);
    pg_in |= P2;
    wait_rails(L3, "R4 wait group 3", c);
    step(STB + 8);
    check("R6 late build holds 2.5V DDR rails", 32'(rail_en_l), 32'h003FFF);
    pg_in |= P3;
    wait_rails(L4, "R4 wait group 4", c);
    step(STB + 8);
    check("R6 late build group 4", 32'(rail_en_l), 32'(L4));
    pg_in |= P4;
    wait_rails(L5, "R4 wait group 5", c);
    check("R4 no power-good before last group", {31'd0, mod_pgood}, 32'd0);
    pg_in |= P5;
    wait_bit(mod_pgood, 1'b1, "R7 wait pgood", c);
    wait_bit(sys_rst_n, 1'b1, "R7 wait release", c);
    check("R7 release hold", c, HOLD);
    fixed_outs("R2 fixed outputs when on");
    check("R6 late build also on", {31'd0, mod_pgood_l}, 32'd1);

    // scenario 2: a reached power-good falls
    expect_obs(0, 0, 0, L5, "R10 pgood and reset drop");
    expect_obs(0, 0, 0, L4, "R10 group 5 off");
    expect_obs(0, 0, 0, L3, "R10 group 4 off");
    expect_obs(0, 0, 0, L2, "R10 group 3 off");
    expect_obs(0, 0, 0, L1, "R10 group 2 off");
    expect_obs(0, 0, 0, 22'd0, "R10 group 1 off");
    expect_obs(0, 0, 0, L1, "R10 restart while enabled");
    pg_in[7] = 1'b0;
    wait_bit(mod_pgood, 1'b0, "R10 wait drop", c);
    pg_in = '0;
    wait_rails(22'd0, "R10 wait off", c);
    check("R10 no fault", {31'd0, fault}, 32'd0);
    wait_rails(L1, "R10 wait restart", c);
    expect_obs(0, 0, 0, 22'd0, "R9 stop from group 1");
    mod_en = 1'b0;
    wait_rails(22'd0, "R9 wait off", c);
    step(10);

    // scenario 3: bring up again, then remove module enable
    expect_obs(0, 0, 0, L1, "R3 second bring-up");
    expect_obs(0, 0, 0, L2, "R4 group 2 again");
    expect_obs(0, 0, 0, L3, "R4 group 3 again");
    expect_obs(0, 0, 0, L4, "R4 group 4 again");
    expect_obs(0, 0, 0, L5, "R4 group 5 again");
    expect_obs(0, 0, 1, L5, "R7 pgood again");
    expect_obs(0, 1, 1, L5, "R7 release again");
    mod_en = 1'b1;
    wait_rails(L1, "R3 wait", c);
    pg_in |= P1;
    wait_rails(L2, "R4 wait", c);
    pg_in |= P2;
    wait_rails(L3, "R4 wait", c);
    pg_in |= P3;
    wait_rails(L4, "R4 wait", c);
    pg_in |= P4;
    wait_rails(L5, "R4 wait", c);
    pg_in |= P5;
    wait_bit(sys_rst_n, 1'b1, "R7 wait", c);
    expect_obs(0, 0, 0, L5, "R9 pgood and reset drop first");
    expect_obs(0, 0, 0, L4, "R9 group 5 off");
    expect_obs(0, 0, 0, L3, "R9 group 4 off");
    expect_obs(0, 0, 0, L2, "R9 group 3 off");
    expect_obs(0, 0, 0, L1, "R9 group 2 off");
    expect_obs(0, 0, 0, 22'd0, "R9 group 1 off");
    mod_en = 1'b0;
    wait_bit(mod_pgood, 1'b0, "R9 wait drop", c);
    wait_rails(22'd0, "R9 wait off", c);
    check("R9 shutdown duration", c, 5 * STP);
    pg_in = '0;
    step(10);

    // scenario 4: group 3 never good -> timeout fault
    expect_obs(0, 0, 0, L1, "R3 third bring-up");
    expect_obs(0, 0, 0, L2, "R4 group 2 before fault");
    expect_obs(0, 0, 0, L3, "R4 group 3 before fault");
    expect_obs(1, 0, 0, L3, "R8 fault raised");
    expect_obs(1, 0, 0, L2, "R8 group 3 off");
    expect_obs(1, 0, 0, L1, "R8 group 2 off");
    expect_obs(1, 0, 0, 22'd0, "R8 group 1 off");
    mod_en = 1'b1;
    wait_rails(L1, "R3 wait", c);
    pg_in |= P1;
    wait_rails(L2, "R4 wait", c);
    pg_in |= P2;
    wait_rails(L3, "R4 wait", c);
    wait_bit(fault, 1'b1, "R8 wait fault", c);
    check("R8 timeout length", c, TMO);
    wait_rails(22'd0, "R8 wait off", c);
    step(30);
    check("R8 fault held", {31'd0, fault}, 32'd1);
    check("R8 rails stay off", 32'(rail_en), 32'd0);
    fixed_outs("R2 fixed outputs in fault");
    expect_obs(0, 0, 0, 22'd0, "R8 fault cleared by enable low");
    mod_en = 1'b0;
    wait_bit(fault, 1'b0, "R8 wait clear", c);
    step(10);
    check("R1 scoreboard drained", exp_q.size(), 0);
    summary();
  end

endmodule